// File: doc/BRIEF.md
# Lockable Memory Configuration Register Bank

This block is a three-register bank that holds the configuration of one on-chip RAM. A simple synchronous bus port lets software set a two-bit test mode, which goes to the RAM wrapper. Software can also request initialization of the RAM, which reaches the wrapper as a one-cycle `init_start` pulse. The wrapper reports completion on `init_done`, and software reads that back as a status bit.

Writes to the configuration register are protected in two layers. A lock bit that software can clear blocks every configuration write while it is set. A commit bit can only be set; once it is 1 the lock bit is frozen, and only reset clears the commit bit. Each register keeps an even-parity bit that is recomputed on every update and checked every cycle. A mismatch raises a sticky error output.

Top module: `memcfg_top`

## Requirements
- R1: After reset, `bus_rdata`, `init_start`, `test_mode` and `parity_error` are 0, and every register reads 0.
- R2: The configuration register is at offset 0x00, the lock register at 0x04 and the commit register at 0x08. `bus_rdata` shows the register addressed one cycle earlier. Any other offset reads 0, and writes to it change nothing.
- R3: A write to 0x00 with bit 16 = 1 while unlocked drives `init_start` high for exactly the following cycle. Bit 16 always reads 0.
- R4: Bit 24 of 0x00 is an init status. It becomes 1 in the cycle after `init_done` is seen high and then holds. An accepted init trigger clears it, and the trigger wins over `init_done` in the same cycle.
- R5: Bits 1:0 of 0x00 are a read/write test-mode field. They drive `test_mode` from the cycle after the write.
- R6: While lock bit 0 of 0x04 is 1, writes to 0x00 have no effect on the test mode, on the init trigger or on the status.
- R7: Writes to 0x04 are ignored while the commit bit is 1.
- R8: Writing 1 to bit 0 of 0x08 sets the commit bit. Writing 0 leaves it unchanged, and only reset returns it to 0.
- R9: All bits other than 1:0 and 24 of 0x00, and bit 0 of 0x04 and 0x08, read as 0.
- R10: Each register carries an even-parity bit. `parity_error` is sticky, and it stays 0 while every stored register matches its parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous address |
| init_done | input | 1 | Initialization finished, from the RAM wrapper |
| init_start | output | 1 | One-cycle request to initialize the RAM |
| test_mode | output | 2 | Test-mode field toward the RAM wrapper |
| parity_error | output | 1 | Sticky register parity mismatch flag |

## Verification
The random stream mixes the three mapped offsets with reserved ones. It sweeps the write strobe, write data, trigger bit and `init_done` freely. This separates accepted writes from writes that are blocked by the lock, blocked by the commit, or sent to unmapped offsets. Directed sequences pin down a trigger and `init_done` arriving together, a locked trigger, a cleared commit write, and a reset in the middle of the run that is the only way to release the commit. Each case is checked against a bench model of the register contents.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

    localparam int DATA_W    = 32;
    localparam int REG_CNT   = 3;
    localparam int REG_STRIDE = 4;

    localparam int IDX_CFG    = 0;
    localparam int IDX_LOCK   = 1;
    localparam int IDX_COMMIT = 2;

    localparam int TM_LSB   = 0;
    localparam int TM_W     = 2;
    localparam int TRIG_BIT = 16;
    localparam int STS_BIT  = 24;
    localparam int KEY_BIT  = 0;

    localparam int STORE_W = TM_W + 1;

    typedef logic [STORE_W-1:0] store_t;

    typedef struct packed {
        logic [TM_W-1:0]    tm;
        logic               sts;
        logic               lock;
        logic               commit;
        logic               start;
        logic [REG_CNT-1:0] par;
        logic               perr;
        logic [DATA_W-1:0]  rdata;
    } state_t;

    function automatic logic even_par(input store_t v);
        return ^v;
    endfunction

endpackage

// File: rtl/memcfg_decode.sv
module memcfg_decode #(
    parameter int ADDR_W  = 8,
    parameter int REG_CNT = 3,
    parameter int STRIDE  = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [REG_CNT-1:0] sel
);
    for (genvar i = 0; i < REG_CNT; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i * STRIDE));
    end
endmodule

// File: rtl/memcfg_parchk.sv
module memcfg_parchk #(
    parameter int REG_CNT = 3,
    parameter int W       = 3
) (
    input  logic [REG_CNT-1:0][W-1:0] data,
    input  logic [REG_CNT-1:0]        par,
    output logic [REG_CNT-1:0]        bad
);
    for (genvar i = 0; i < REG_CNT; i++) begin : g_chk
        assign bad[i] = ^{data[i], par[i]};
    end
endmodule

// File: rtl/memcfg_top.sv
module memcfg_top
    import memcfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              init_done,
    output logic              init_start,
    output logic [TM_W-1:0]   test_mode,
    output logic              parity_error
);
    localparam int PAD_W = STORE_W - 1;

    state_t d, q;

    logic [REG_CNT-1:0]              sel;
    logic [REG_CNT-1:0][STORE_W-1:0] store_q;
    logic [REG_CNT-1:0][STORE_W-1:0] store_d;
    logic [REG_CNT-1:0]              bad;
    logic                            lock_bit;
    logic                            commit_bit;
    logic                            unused_wdata;

    assign unused_wdata = ^{bus_wdata[DATA_W-1:TRIG_BIT+1],
                            bus_wdata[TRIG_BIT-1:TM_W]};

    memcfg_decode #(
        .ADDR_W (ADDR_W),
        .REG_CNT(REG_CNT),
        .STRIDE (REG_STRIDE)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    // Stored content per register, in a common width for parity
    assign store_q[IDX_CFG]    = {q.sts, q.tm};
    assign store_q[IDX_LOCK]   = {{PAD_W{1'b0}}, q.lock};
    assign store_q[IDX_COMMIT] = {{PAD_W{1'b0}}, q.commit};

    memcfg_parchk #(
        .REG_CNT(REG_CNT),
        .W      (STORE_W)
    ) u_par (
        .data(store_q),
        .par (q.par),
        .bad (bad)
    );

    always_comb begin
        logic cfg_wr;
        logic trig;
        logic [DATA_W-1:0] rd;

        d = q;

        cfg_wr = bus_we && sel[IDX_CFG] && !q.lock;
        trig   = cfg_wr && bus_wdata[TRIG_BIT];

        if (cfg_wr) begin
            d.tm = bus_wdata[TM_LSB +: TM_W];
        end

        if (trig) begin
            d.sts = 1'b0;
        end else if (init_done) begin
            d.sts = 1'b1;
        end

        if (bus_we && sel[IDX_LOCK] && !q.commit) begin
            d.lock = bus_wdata[KEY_BIT];
        end

        if (bus_we && sel[IDX_COMMIT] && bus_wdata[KEY_BIT]) begin
            d.commit = 1'b1;
        end

        d.start = trig;

        store_d[IDX_CFG]    = {d.sts, d.tm};
        store_d[IDX_LOCK]   = {{PAD_W{1'b0}}, d.lock};
        store_d[IDX_COMMIT] = {{PAD_W{1'b0}}, d.commit};
        for (int i = 0; i < REG_CNT; i++) begin
            d.par[i] = even_par(store_d[i]);
        end

        d.perr = q.perr || (|bad);

        rd = '0;
        if (sel[IDX_CFG]) begin
            rd[TM_LSB +: TM_W] = q.tm;
            rd[STS_BIT]        = q.sts;
        end
        if (sel[IDX_LOCK]) begin
            rd[KEY_BIT] = q.lock;
        end
        if (sel[IDX_COMMIT]) begin
            rd[KEY_BIT] = q.commit;
        end
        d.rdata = rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata    = q.rdata;
    assign init_start   = q.start;
    assign test_mode    = q.tm;
    assign parity_error = q.perr;
    assign lock_bit     = q.lock;
    assign commit_bit   = q.commit;

endmodule

// File: rtl/memcfg_checks.sv
module memcfg_checks
    import memcfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              init_start,
    input logic [TM_W-1:0]   test_mode,
    input logic              parity_error,
    input logic              lock_bit,
    input logic              commit_bit
);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(IDX_CFG * REG_STRIDE);
    localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(IDX_LOCK * REG_STRIDE);
    localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(IDX_COMMIT * REG_STRIDE);

    logic mapped;
    logic [DATA_W-1:0] rsv_mask;
    assign mapped = (bus_addr == A_CFG) || (bus_addr == A_LOCK) || (bus_addr == A_COMMIT);

    always_comb begin
        rsv_mask = '1;
        rsv_mask[TM_LSB +: TM_W] = 1'b0;
        rsv_mask[STS_BIT] = 1'b0;
    end

    a_r3_start_source: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> $past(bus_we && bus_addr == A_CFG && bus_wdata[TRIG_BIT] && !lock_bit));

    a_r6_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CFG && lock_bit) |=> ($stable(test_mode) && !init_start));

    a_r7_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        commit_bit |=> $stable(lock_bit));

    a_r8_commit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        commit_bit |=> commit_bit);

    a_r2_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !mapped) |=> ($stable(test_mode) && $stable(lock_bit) && $stable(commit_bit) && !init_start));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & rsv_mask) == '0);

    a_r10_parity_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_error);
endmodule

bind memcfg_top memcfg_checks #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .init_start  (init_start),
    .test_mode   (test_mode),
    .parity_error(parity_error),
    .lock_bit    (lock_bit),
    .commit_bit  (commit_bit)
);

// File: tb/memcfg_top_test.sv
`timescale 1ns/1ps
module memcfg_top_test;
    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        init_done = 1'b0;
    logic        init_start;
    logic [1:0]  test_mode;
    logic        parity_error;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [1:0] m_tm;
    logic       m_sts, m_lock, m_commit;

    always #2.5 clk = ~clk;

    memcfg_top #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_done(init_done),
        .init_start(init_start), .test_mode(test_mode), .parity_error(parity_error)
    );

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        logic [31:0] v = '0;
        if (a == 8'h00) begin v[1:0] = m_tm; v[24] = m_sts; end
        else if (a == 8'h04) v[0] = m_lock;
        else if (a == 8'h08) v[0] = m_commit;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tm = '0; m_sts = 1'b0; m_lock = 1'b0; m_commit = 1'b0;
    endtask

    // One bus cycle: drive at negedge, check at the following negedge
    task automatic cycle(input logic [AW-1:0] a, input logic we, input logic [31:0] wd, input logic done);
        logic [31:0] e_rd;
        logic        e_start, cfg_wr;
        bus_addr = a; bus_we = we; bus_wdata = wd; init_done = done;
        e_rd   = exp_read(a);
        cfg_wr = we && a == 8'h00 && !m_lock;
        e_start = cfg_wr && wd[16];
        if (cfg_wr) m_tm = wd[1:0];
        if (e_start) m_sts = 1'b0; else if (done) m_sts = 1'b1;
        if (we && a == 8'h04 && !m_commit) m_lock = wd[0];
        if (we && a == 8'h08 && wd[0]) m_commit = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check((a == 8'h00 || a == 8'h04 || a == 8'h08) ? "R2/R9 readback" : "R2 reserved read",
              bus_rdata, e_rd);
        check("R3 init_start", 32'(init_start), 32'(e_start));
        check("R5 test_mode", 32'(test_mode), 32'(m_tm));
        check("R10 parity_error", 32'(parity_error), 32'd0);
    endtask

    task automatic peek(input logic [AW-1:0] a, input string req, input logic [31:0] exp);
        bus_addr = a; bus_we = 1'b0; init_done = 1'b0;
        if (m_sts == 1'b0) m_sts = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_we = 1'b0; init_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        @(negedge clk);
        do_reset();
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", bus_rdata, 32'd0);
        check("R1 init_start", 32'(init_start), 32'd0);
        check("R1 test_mode", 32'(test_mode), 32'd0);
        check("R1 parity_error", 32'(parity_error), 32'd0);
        peek(8'h00, "R1 cfg", 32'd0);
        peek(8'h04, "R1 lock", 32'd0);
        peek(8'h08, "R1 commit", 32'd0);

        // R5 test mode, R3 trigger reads 0
        cycle(8'h00, 1'b1, 32'hFFFF_FFFE, 1'b0);
        peek(8'h00, "R3 R9 trigger bit reads 0", 32'h0000_0002);
        // R4 status set by init_done, trigger wins over done
        cycle(8'h10, 1'b0, 32'h0, 1'b1);
        peek(8'h00, "R4 status set", 32'h0100_0002);
        cycle(8'h00, 1'b1, 32'h0001_0003, 1'b1);
        peek(8'h00, "R4 trigger clears status", 32'h0000_0003);
        // R6 lock blocks cfg writes
        cycle(8'h04, 1'b1, 32'h1, 1'b0);
        cycle(8'h00, 1'b1, 32'h0001_0000, 1'b0);
        peek(8'h00, "R6 locked cfg unchanged", 32'h0000_0003);
        cycle(8'h04, 1'b1, 32'h0, 1'b0);
        // R2 reserved writes ignored
        cycle(8'h0C, 1'b1, 32'hFFFF_FFFF, 1'b0);
        cycle(8'h01, 1'b1, 32'hFFFF_FFFF, 1'b0);
        peek(8'h04, "R2 reserved write no effect on lock", 32'h0);
        peek(8'h08, "R2 reserved write no effect on commit", 32'h0);
        // R8 commit: writing 0 no effect, writing 1 sets
        cycle(8'h08, 1'b1, 32'h0, 1'b0);
        peek(8'h08, "R8 zero write ignored", 32'h0);
        cycle(8'h04, 1'b1, 32'h1, 1'b0);
        cycle(8'h08, 1'b1, 32'h1, 1'b0);
        // R7 lock frozen
        cycle(8'h04, 1'b1, 32'h0, 1'b0);
        peek(8'h04, "R7 lock frozen", 32'h1);
        cycle(8'h08, 1'b1, 32'h0, 1'b0);
        peek(8'h08, "R8 commit sticky", 32'h1);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            logic [31:0] wd;
            int pick;
            pick = $urandom_range(0, 9);
            if (pick < 3) a = 8'h00;
            else if (pick < 5) a = 8'h04;
            else if (pick < 6) a = 8'h08;
            else a = AW'($urandom);
            wd = $urandom;
            if ($urandom_range(0, 3) != 0) wd[16] = 1'b0;
            if (a == 8'h08 && $urandom_range(0, 7) != 0) wd[0] = 1'b0;
            cycle(a, 1'($urandom_range(0, 1)), wd, ($urandom_range(0, 5) == 0));
            if (n == 1500) begin
                // R8: only reset releases commit
                do_reset();
                peek(8'h08, "R8 reset clears commit", 32'h0);
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule